// File: doc/BRIEF.md
# Per-Hart Timebase Copy with Debug Freeze

This block keeps, for each hart of a cluster, a local copy of a system timebase that is counted elsewhere on the chip. A single shared tracker rebuilds the timebase value from what the chip delivers. That is either the full value on every cycle, or an increment strobe plus a load strobe that carries a full value for resynchronisation. Each hart owns a hold register that takes the tracker's value on every clock edge. It stops taking it while that hart is halted for debug with its stop-time control set.

The tracker never stops, so a halted hart does not disturb the shared value or any other hart. When the freeze ends, the hart's copy takes the tracker's current value on the next edge. It does not continue from the frozen value. The same path resynchronises the copy after reset, after the timebase is rewritten, and after a wake from sleep. In increment mode the source signals the last two with the load strobe. Each hart also has a stop-count control bit. It produces a hold signal for that hart's retired-instruction counter while the hart is in debug.

Top module: `tbc_timebase_copy`

## Requirements
- R1: During and right after reset every copy reads 0 and every hart's stop-time bit reads 1. The stop-count bit also resets to 1, and this shows as an asserted instruction-counter hold once the hart enters debug.
- R2: With SRC=SRC_FULL (0), a hart that is not frozen presents, after each clock edge, the timebase value sampled at that edge.
- R3: With SRC=SRC_INCR (1), a tick strobe advances the shared value by one, and a load strobe replaces it with the timebase input. When both strobes occur in the same cycle, the load wins.
- R4: A hart is frozen when its debug-mode input is 1, its stop-time bit is 1 and its debug-exit pulse is 0. While frozen, its copy keeps the value it held on the edge before it entered debug, and it ignores ticks, loads and value changes.
- R5: The shared value keeps advancing while any hart is frozen, and the copies of the other harts keep tracking it.
- R6: On the first edge at which a freeze ends, either because debug mode drops or because the debug-exit pulse is seen, the copy equals the current shared value, not the frozen value plus one.
- R7: With the stop-time bit at 0, debug mode has no effect on the copy.
- R8: Clearing stop-time while the hart stays in debug resynchronises the copy at the following edge.
- R9: The instruction-counter hold output of a hart equals its debug-mode input ANDed with its stop-count bit. A control write (ctl_we_i bit h) loads both control bits of hart h at the next edge.
- R10: Any two harts that are both unfrozen hold equal copies after each edge.
- R11: The shared value wraps from all ones to zero on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_value_i | input | TW | Timebase value from the shared counter |
| tb_tick_i | input | 1 | Increment strobe (increment mode) |
| tb_load_i | input | 1 | Resynchronise strobe: load tb_value_i (increment mode) |
| dbg_mode_i | input | NH | Per-hart debug-mode status |
| dbg_exit_i | input | NH | Per-hart debug-return pulse |
| ctl_we_i | input | NH | Per-hart control write enable |
| ctl_stoptime_i | input | 1 | Stop-time value written |
| ctl_stopcount_i | input | 1 | Stop-count value written |
| copy_o | output | NH x TW | Per-hart timebase copy (read port) |
| stoptime_o | output | NH | Per-hart stop-time bit readback |
| instret_hold_o | output | NH | Per-hart retired-instruction counter hold |

## Verification
Two instances, one per source mode, receive the same shared counter: a full value in one and ticks plus loads in the other. Any disagreement between them therefore separates a tracking fault from a stimulus artefact. Freezes are tried with plain debug entry and exit, with the exit pulse while debug is still high, with stop-time cleared, and with stop-time released mid-halt. Each distinguishes a hold that is merely slow from one that resynchronises correctly. Loads during a freeze, a simultaneous tick and load, and a wrap from all ones show whether the shared value and the frozen copy stay independent.

// File: rtl/tbc_pkg.sv
// Package: shared types for the timebase copy block.
package tbc_pkg;
    // How the shared timebase reaches the cluster.
    typedef enum logic {
        SRC_FULL = 1'b0,  // full value delivered every cycle
        SRC_INCR = 1'b1   // increment strobe plus full-value load strobe
    } tb_src_e;

    // Per-hart debug controls.
    typedef struct packed {
        logic stop_time;
        logic stop_count;
    } dbg_ctl_t;

    localparam dbg_ctl_t CTL_RESET = '{stop_time: 1'b1, stop_count: 1'b1};
endpackage

// File: rtl/tbc_shadow.sv
// Module: tbc_shadow
// Rebuilds the shared timebase inside the cluster. It never stops, so it is
// always the resynchronisation source for the per-hart copies.
// Assumes: in SRC_INCR the source pulses load after reset, after a timebase
// write and after a wake from sleep.
module tbc_shadow
    import tbc_pkg::*;
#(
    parameter int      TW  = 64,
    parameter tb_src_e SRC = SRC_FULL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tb_value_i,
    input  logic          tb_tick_i,
    input  logic          tb_load_i,
    output logic [TW-1:0] shadow_next_o,
    output logic [TW-1:0] shadow_q_o
);
    localparam logic [TW-1:0] ONE = TW'(1);

    logic [TW-1:0] nxt;

    generate
        if (SRC == SRC_FULL) begin : g_full
            logic unused_strobes;
            assign unused_strobes = tb_tick_i ^ tb_load_i;
            // Next value: the broadcast value itself.
            always_comb nxt = tb_value_i;
        end else begin : g_incr
            // Next value: load wins over tick; tick wraps modulo 2^TW.
            always_comb begin
                if (tb_load_i)      nxt = tb_value_i;
                else if (tb_tick_i) nxt = shadow_q_o + ONE;
                else                nxt = shadow_q_o;
            end
        end
    endgenerate

    // Shared value register.
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q_o <= '0;
        else        shadow_q_o <= nxt;
    end

    assign shadow_next_o = nxt;
endmodule

// File: rtl/tbc_dbg_ctrl.sv
// Module: tbc_dbg_ctrl
// Holds one hart's stop-time and stop-count bits and derives the freeze and
// counter-hold conditions. Assumes the debug-exit pulse lasts one cycle.
module tbc_dbg_ctrl
    import tbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_we_i,
    input  logic ctl_stoptime_i,
    input  logic ctl_stopcount_i,
    input  logic dbg_mode_i,
    input  logic dbg_exit_i,
    output logic freeze_o,
    output logic stoptime_o,
    output logic instret_hold_o
);
    dbg_ctl_t ctl_q;

    // Control bits: reset to stop both, loaded on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_q <= CTL_RESET;
        else if (ctl_we_i) ctl_q <= '{stop_time: ctl_stoptime_i, stop_count: ctl_stopcount_i};
    end

    // Freeze lifts on the exit pulse even if debug status lags by a cycle.
    always_comb freeze_o = dbg_mode_i & ctl_q.stop_time & ~dbg_exit_i;
    // Counter hold follows debug status and stop-count.
    always_comb instret_hold_o = dbg_mode_i & ctl_q.stop_count;

    assign stoptime_o = ctl_q.stop_time;
endmodule

// File: rtl/tbc_hart_copy.sv
// Module: tbc_hart_copy
// One hart's visible timebase copy. It takes the shared next value on every
// edge unless frozen, so it rejoins the shared value on the first free edge.
module tbc_hart_copy #(
    parameter int TW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze_i,
    input  logic [TW-1:0] shadow_next_i,
    output logic [TW-1:0] copy_o
);
    // Copy register: hold when frozen, otherwise follow the shared value.
    always_ff @(posedge clk) begin
        if (!rst_n)         copy_o <= '0;
        else if (!freeze_i) copy_o <= shadow_next_i;
    end
endmodule

// File: rtl/tbc_timebase_copy.sv
// Module: tbc_timebase_copy (top)
// One shared timebase tracker feeding NH per-hart copies, each with its own
// debug freeze control. Assumes all inputs are synchronous to clk.
module tbc_timebase_copy
    import tbc_pkg::*;
#(
    parameter int      NH  = 2,
    parameter int      TW  = 64,
    parameter tb_src_e SRC = SRC_FULL
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [TW-1:0]          tb_value_i,
    input  logic                   tb_tick_i,
    input  logic                   tb_load_i,
    input  logic [NH-1:0]          dbg_mode_i,
    input  logic [NH-1:0]          dbg_exit_i,
    input  logic [NH-1:0]          ctl_we_i,
    input  logic                   ctl_stoptime_i,
    input  logic                   ctl_stopcount_i,
    output logic [NH-1:0][TW-1:0]  copy_o,
    output logic [NH-1:0]          stoptime_o,
    output logic [NH-1:0]          instret_hold_o
);
    logic [TW-1:0] shadow_next;
    logic [TW-1:0] shadow_q;
    logic [NH-1:0] frz;

    tbc_shadow #(.TW(TW), .SRC(SRC)) u_shadow (
        .clk           (clk),
        .rst_n         (rst_n),
        .tb_value_i    (tb_value_i),
        .tb_tick_i     (tb_tick_i),
        .tb_load_i     (tb_load_i),
        .shadow_next_o (shadow_next),
        .shadow_q_o    (shadow_q)
    );

    generate
        for (genvar h = 0; h < NH; h++) begin : g_hart
            tbc_dbg_ctrl u_ctl (
                .clk             (clk),
                .rst_n           (rst_n),
                .ctl_we_i        (ctl_we_i[h]),
                .ctl_stoptime_i  (ctl_stoptime_i),
                .ctl_stopcount_i (ctl_stopcount_i),
                .dbg_mode_i      (dbg_mode_i[h]),
                .dbg_exit_i      (dbg_exit_i[h]),
                .freeze_o        (frz[h]),
                .stoptime_o      (stoptime_o[h]),
                .instret_hold_o  (instret_hold_o[h])
            );
            tbc_hart_copy #(.TW(TW)) u_copy (
                .clk           (clk),
                .rst_n         (rst_n),
                .freeze_i      (frz[h]),
                .shadow_next_i (shadow_next),
                .copy_o        (copy_o[h])
            );
        end
    endgenerate
endmodule

// File: rtl/tbc_checker.sv
// Module: tbc_checker
// Temporal checks on the timebase copy block, bound to every instance.
module tbc_checker
    import tbc_pkg::*;
#(
    parameter int      NH  = 2,
    parameter int      TW  = 64,
    parameter tb_src_e SRC = SRC_FULL
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [TW-1:0]         tb_value_i,
    input logic                  tb_tick_i,
    input logic                  tb_load_i,
    input logic [NH-1:0]         dbg_mode_i,
    input logic [NH-1:0]         dbg_exit_i,
    input logic [NH-1:0]         stoptime_o,
    input logic [NH-1:0][TW-1:0] copy_o,
    input logic [TW-1:0]         shadow_q
);
    logic [NH-1:0] f;
    assign f = dbg_mode_i & stoptime_o & ~dbg_exit_i;

    generate
        for (genvar h = 0; h < NH; h++) begin : g_h
            // R4: frozen hart keeps its copy
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                f[h] |=> $stable(copy_o[h]));
            // R2, R6: an unfrozen hart matches the shared value after the edge
            a_r6_track: assert property (@(posedge clk) disable iff (!rst_n)
                !f[h] |=> (copy_o[h] == shadow_q));
            if (h > 0) begin : g_pair
                // R10: unfrozen harts agree
                a_r10_agree: assert property (@(posedge clk) disable iff (!rst_n)
                    (!f[0] && !f[h]) |=> (copy_o[h] == copy_o[0]));
            end
        end
        if (SRC == SRC_INCR) begin : g_incr
            // R3: tick advances by one (wrapping, R11)
            a_r3_tick: assert property (@(posedge clk) disable iff (!rst_n)
                (tb_tick_i && !tb_load_i) |=> (shadow_q == $past(shadow_q) + TW'(1)));
            // R3: load takes the input value
            a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
                tb_load_i |=> (shadow_q == $past(tb_value_i)));
        end else begin : g_full
            // R2: shared value follows the broadcast value
            a_r2_full: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (shadow_q == $past(tb_value_i)));
        end
    endgenerate
endmodule

bind tbc_timebase_copy tbc_checker #(.NH(NH), .TW(TW), .SRC(SRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tb_value_i (tb_value_i),
    .tb_tick_i  (tb_tick_i),
    .tb_load_i  (tb_load_i),
    .dbg_mode_i (dbg_mode_i),
    .dbg_exit_i (dbg_exit_i),
    .stoptime_o (stoptime_o),
    .copy_o     (copy_o),
    .shadow_q   (shadow_q)
);

// File: tb/tb_tbc_timebase_copy.sv
`timescale 1ns/1ps
// Directed bench: one full-value instance and one increment-mode instance
// share all inputs; the bench keeps its own model of the shared counter.
module tb_tbc_timebase_copy;
    import tbc_pkg::*;
    localparam int NH = 2;
    localparam int TW = 64;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic [TW-1:0]         tb_value;
    logic                  tb_tick, tb_load;
    logic [NH-1:0]         dbg_mode, dbg_exit, ctl_we;
    logic                  ctl_st, ctl_sc;
    logic [NH-1:0][TW-1:0] copy_f, copy_i;
    logic [NH-1:0]         st_f, st_i, hold_f, hold_i;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [TW-1:0] mtime;
    logic [TW-1:0] frozen;

    always #4 clk = ~clk;

    tbc_timebase_copy #(.NH(NH), .TW(TW), .SRC(SRC_FULL)) dut (
        .clk(clk), .rst_n(rst_n), .tb_value_i(tb_value), .tb_tick_i(tb_tick),
        .tb_load_i(tb_load), .dbg_mode_i(dbg_mode), .dbg_exit_i(dbg_exit),
        .ctl_we_i(ctl_we), .ctl_stoptime_i(ctl_st), .ctl_stopcount_i(ctl_sc),
        .copy_o(copy_f), .stoptime_o(st_f), .instret_hold_o(hold_f));

    tbc_timebase_copy #(.NH(NH), .TW(TW), .SRC(SRC_INCR)) dut_inc (
        .clk(clk), .rst_n(rst_n), .tb_value_i(tb_value), .tb_tick_i(tb_tick),
        .tb_load_i(tb_load), .dbg_mode_i(dbg_mode), .dbg_exit_i(dbg_exit),
        .ctl_we_i(ctl_we), .ctl_stoptime_i(ctl_st), .ctl_stopcount_i(ctl_sc),
        .copy_o(copy_i), .stoptime_o(st_i), .instret_hold_o(hold_i));

    task automatic check(input string req, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Check hart h in both instances.
    task automatic check_hart(input string req, input int h, input logic [TW-1:0] exp);
        check({req, " full"}, copy_f[h], exp);
        check({req, " incr"}, copy_i[h], exp);
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    // Shared counter advances n times.
    task automatic adv(input int n);
        for (int k = 0; k < n; k++) begin
            mtime = mtime + 1'b1;
            tb_value = mtime;
            tb_tick = 1'b1;
            cyc();
            tb_tick = 1'b0;
        end
    endtask

    // Shared counter rewritten; load strobe resynchronises.
    task automatic wr_tb(input logic [TW-1:0] v);
        mtime = v;
        tb_value = v;
        tb_load = 1'b1;
        cyc();
        tb_load = 1'b0;
    endtask

    task automatic wr_ctl(input int h, input logic st, input logic sc);
        ctl_st = st;
        ctl_sc = sc;
        ctl_we = '0;
        ctl_we[h] = 1'b1;
        cyc();
        ctl_we = '0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tb_value = '0; tb_tick = 0; tb_load = 0;
        dbg_mode = '0; dbg_exit = '0; ctl_we = '0; ctl_st = 0; ctl_sc = 0;
        mtime = '0;
        repeat (3) cyc();
        check_hart("R1 copy0 in reset", 0, '0);
        check("R1 stoptime reset full", TW'(st_f), TW'(2'b11));
        check("R1 stoptime reset incr", TW'(st_i), TW'(2'b11));
        rst_n = 1'b1;
        cyc();
        check_hart("R1 copy1 after reset", 1, '0);
    endtask

    task automatic t_track();
        wr_tb(64'h1000);
        check_hart("R3 load sync", 0, 64'h1000);
        adv(5);
        check_hart("R2 track h0", 0, mtime);
        check_hart("R2 track h1", 1, mtime);
        // Simultaneous tick and load: load wins.
        mtime = 64'h77; tb_value = mtime; tb_tick = 1; tb_load = 1;
        cyc();
        tb_tick = 0; tb_load = 0;
        check_hart("R3 load over tick", 0, 64'h77);
    endtask

    task automatic t_freeze();
        frozen = mtime;
        dbg_mode[0] = 1'b1;
        adv(4);
        check_hart("R4 frozen", 0, frozen);
        check_hart("R5 other hart runs", 1, mtime);
        check("R9 count hold reset 1", TW'(hold_f[0]), TW'(1));
        check("R9 count hold idle hart", TW'(hold_i[1]), TW'(0));
        wr_tb(64'h5000);
        adv(2);
        check_hart("R4 ignores load", 0, frozen);
        check_hart("R5 shared loaded", 1, mtime);
        dbg_mode[0] = 1'b0;
        adv(1);
        check_hart("R6 exit resync", 0, mtime);
        // Exit pulse while status still high.
        dbg_mode[0] = 1'b1;
        adv(3);
        dbg_exit[0] = 1'b1;
        adv(1);
        check_hart("R6 exit pulse", 0, mtime);
        dbg_exit[0] = 1'b0; dbg_mode[0] = 1'b0;
        adv(1);
        check_hart("R10 harts agree", 0, copy_f[1]);
    endtask

    task automatic t_nostop();
        wr_ctl(1, 1'b0, 1'b0);
        check("R9 stoptime write", TW'(st_f), TW'(2'b01));
        dbg_mode[1] = 1'b1;
        adv(3);
        check_hart("R7 no stop", 1, mtime);
        check("R9 count hold cleared", TW'(hold_i[1]), TW'(0));
        dbg_mode[1] = 1'b0;
    endtask

    task automatic t_release();
        dbg_mode[0] = 1'b1;
        adv(2);
        frozen = copy_f[0];
        wr_ctl(0, 1'b0, 1'b1);
        check_hart("R8 held during write", 0, frozen);
        adv(1);
        check_hart("R8 release resync", 0, mtime);
        wr_ctl(0, 1'b1, 1'b1);
        dbg_mode[0] = 1'b0;
        adv(1);
    endtask

    task automatic t_wrap();
        wr_tb('1);
        check_hart("R11 all ones", 0, '1);
        adv(1);
        check_hart("R11 wrap to zero", 0, '0);
    endtask

    initial begin
        t_reset();
        t_track();
        t_freeze();
        t_nostop();
        t_release();
        t_wrap();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule